// File: doc/BRIEF.md
# ECC Syndrome to DIMM Locator

This block turns the syndrome code of a corrected memory error, together with the physical address of the access, into the memory module that holds the failing bit and the connector pin that carries it. Board wiring is described by byte tables that the controller loads through a write port: a module-select bitmap, a pin table and a flag that chooses between two map sets. Once loaded, a lookup is started with a one-cycle request strobe. One cycle later the result appears, marked by a done pulse.

Two bus layouts are handled, chosen per lookup by `wide_mode`. In the wide layout a 64-byte line travels as four 144-bit quadwords. The quadwords are placed in the line in reverse order, and each bitmap byte packs four 2-bit module fields. In the narrow layout only one 144-bit quadword exists, and each bitmap byte packs eight 1-bit fields. Before the tables are indexed, the syndrome code is moved onto its bus bit position by a piecewise remap. The narrow layout always reads map set 0, using bitmap bytes 0..17 and pin entries 0..143.

Top module: `ecc_dimm_locator`

## Requirements
- R1: A syndrome code below -1 or above 144 gives invalid=1 with done. In that case multi=0, dimm_mask=0, dimm_idx=0 and pin=0.
- R2: Code -1 gives multi=1 and pin=0, with dimm_idx equal to the group base. The group base is grp_sel*4 (wide) or grp_sel*2 (narrow). dimm_mask holds ones for the base and the modules above it in that group: four modules (wide) or two (narrow).
- R3: A code c in 0..144 is remapped to bus bit r as follows. For c<128, r=c+16. For 128..136, r=c-121. For 137..139, r=c-133. For 140..144, r=c-140.
- R4: Wide layout: q=line_addr[5:4] and the line offset is off=(3-q)*144+r. pin equals the pin table byte at index off of the selected set.
- R5: Wide layout: v=575-off. The module field is bits [2k+1:2k] of bitmap byte v>>2, where k=3-(v&3). dimm_idx=grp_sel*4+field and dimm_mask=1<<dimm_idx.
- R6: Narrow layout: off=r and v=143-off. The field is bit 7-(v&7) of bitmap byte v>>3. dimm_idx=grp_sel*2+field, and pin is the set-0 pin table byte at index off. line_addr has no effect.
- R7: In the wide layout the map set is 0 when the symmetric flag is 1 and set 1 when it is 0. The narrow layout always uses set 0.
- R8: A table write occurs when tbl_we=1. tbl_sel=0 writes bitmap byte tbl_addr[7:0] of set tbl_set. tbl_sel=1 writes pin byte tbl_addr[9:0] of set tbl_set. tbl_sel=2 loads the symmetric flag from tbl_wdata[0].
- R9: A lookup strobed by req at one rising edge drives done high for exactly one cycle after that edge, with its results. Lookups may be issued in back-to-back cycles. While done is low, all result outputs are 0.
- R10: A table write and a lookup in the same cycle are ordered read-first: the lookup returns the old contents, and a later lookup sees the new byte.
- R11: After reset, done, invalid and multi are 0, the outputs are 0 and the symmetric flag is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wide_mode | input | 1 | 1 selects the four-quadword layout for this lookup |
| tbl_we | input | 1 | Table write strobe |
| tbl_sel | input | 2 | Write target: 0 bitmap, 1 pin table, 2 symmetric flag |
| tbl_set | input | 1 | Map set written |
| tbl_addr | input | 10 | Byte index in the table |
| tbl_wdata | input | 8 | Write data |
| req | input | 1 | Lookup strobe |
| syn_code | input | 10 | Signed syndrome code |
| line_addr | input | 16 | Low bits of the physical address |
| grp_sel | input | 1 | Bank LSB (wide) or group index (narrow) |
| done | output | 1 | Result valid pulse |
| invalid | output | 1 | Code out of range |
| multi | output | 1 | Multi-bit error, whole group flagged |
| dimm_idx | output | 3 | Failing module index |
| dimm_mask | output | 8 | One bit per module flagged |
| pin | output | 8 | Failing pin number |

## Verification
The table write port and the lookup path can act in the same cycle. A pin byte can be rewritten at the very offset that the lookup strobed in that cycle reads. The bench provokes this with a wide-layout lookup whose offset it knows in advance. It writes a changed value to that offset in the same cycle. It expects the old byte from that lookup and the new byte from the next one. Back-to-back requests also check that each done result is matched to its own request in order.

// File: rtl/ecc_loc_pkg.sv
package ecc_loc_pkg;
  // table write targets
  localparam logic [1:0] TSEL_DMAP = 2'd0;
  localparam logic [1:0] TSEL_PMAP = 2'd1;
  localparam logic [1:0] TSEL_SYM  = 2'd2;

  // syndrome range and remap segment limits
  localparam int CODE_MULTI = -1;
  localparam int CODE_MAX   = 144;
  localparam int SEG_DATA   = 128;  // below: data bits
  localparam int SEG_CHK    = 137;  // below: check bits
  localparam int SEG_TAG    = 140;  // below: tag bits

  // module-select field widths per layout
  localparam int WIDE_FW   = 2;
  localparam int NARROW_FW = 1;
endpackage

// File: rtl/ecc_syn_remap.sv
module ecc_syn_remap
  import ecc_loc_pkg::*;
#(
  parameter int SYN_W = 10,
  parameter int RC_W  = 8
) (
  input  logic signed [SYN_W-1:0] syn,
  output logic                    in_range,
  output logic                    is_multi,
  output logic [RC_W-1:0]         rcode
);
  always_comb begin
    int s;
    s        = int'(syn);
    in_range = (s >= CODE_MULTI) && (s <= CODE_MAX);
    is_multi = (s == CODE_MULTI);
    if (!in_range || is_multi)  rcode = '0;
    else if (s < SEG_DATA)      rcode = RC_W'(s + 16);
    else if (s < SEG_CHK)       rcode = RC_W'(s - 121);
    else if (s < SEG_TAG)       rcode = RC_W'(s - 133);
    else                        rcode = RC_W'(s - 140);
  end
endmodule

// File: rtl/ecc_loc_addr.sv
module ecc_loc_addr
  import ecc_loc_pkg::*;
#(
  parameter int QW_BITS = 144,
  parameter int LINE_QW = 4,
  parameter int QW_IW   = 2,
  parameter int RC_W    = 8,
  parameter int OFF_W   = 10,
  parameter int DB_W    = 8
) (
  input  logic             wide,
  input  logic [QW_IW-1:0] qw,
  input  logic [RC_W-1:0]  rcode,
  output logic [OFF_W-1:0] off,
  output logic [DB_W-1:0]  dbyte,
  output logic [2:0]       shift
);
  localparam int WIDE_PER_B   = 8 / WIDE_FW;
  localparam int NARROW_PER_B = 8 / NARROW_FW;

  always_comb begin
    int o, inv, k;
    if (wide) begin
      o     = (LINE_QW - 1 - int'(qw)) * QW_BITS + int'(rcode);
      inv   = LINE_QW * QW_BITS - 1 - o;
      k     = inv % WIDE_PER_B;
      dbyte = DB_W'(inv / WIDE_PER_B);
      shift = 3'((WIDE_PER_B - 1 - k) * WIDE_FW);
    end else begin
      o     = int'(rcode);
      inv   = QW_BITS - 1 - o;
      k     = inv % NARROW_PER_B;
      dbyte = DB_W'(inv / NARROW_PER_B);
      shift = 3'((NARROW_PER_B - 1 - k) * NARROW_FW);
    end
    off = OFF_W'(o);
  end
endmodule

// File: rtl/ecc_loc_ram.sv
module ecc_loc_ram #(
  parameter int AW = 9,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [1<<AW];

  // single process: the read sees the value before a same-edge write
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/ecc_dimm_locator.sv
module ecc_dimm_locator
  import ecc_loc_pkg::*;
#(
  parameter int SYN_W      = 10,
  parameter int ADDR_W     = 16,
  parameter int QW_BITS    = 144,
  parameter int LINE_QW    = 4,
  parameter int LINE_BYTES = 64,
  parameter int MAP_W      = 8,
  parameter int WIDE_GRP   = 4,
  parameter int NARROW_GRP = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wide_mode,
  input  logic                    tbl_we,
  input  logic [1:0]              tbl_sel,
  input  logic                    tbl_set,
  input  logic [$clog2(LINE_QW*QW_BITS)-1:0] tbl_addr,
  input  logic [MAP_W-1:0]        tbl_wdata,
  input  logic                    req,
  input  logic signed [SYN_W-1:0] syn_code,
  input  logic [ADDR_W-1:0]       line_addr,
  input  logic                    grp_sel,
  output logic                    done,
  output logic                    invalid,
  output logic                    multi,
  output logic [$clog2(2*WIDE_GRP)-1:0] dimm_idx,
  output logic [2*WIDE_GRP-1:0]   dimm_mask,
  output logic [MAP_W-1:0]        pin
);
  localparam int LINE_BITS = LINE_QW * QW_BITS;
  localparam int OFF_W     = $clog2(LINE_BITS);
  localparam int RC_W      = $clog2(QW_BITS);
  localparam int DB_W      = $clog2(LINE_BITS * WIDE_FW / 8);
  localparam int QW_IW     = $clog2(LINE_QW);
  localparam int QW_LSB    = $clog2(LINE_BYTES / LINE_QW);
  localparam int NDIMM     = 2 * WIDE_GRP;
  localparam int DI_W      = $clog2(NDIMM);

  // ---------------- lookup address path
  logic            rm_in, rm_multi;
  logic [RC_W-1:0] rcode;
  logic [OFF_W-1:0] off;
  logic [DB_W-1:0] dbyte;
  logic [2:0]      shift;
  logic [QW_IW-1:0] qw;
  logic            unused_addr_bits;

  assign qw = line_addr[QW_LSB +: QW_IW];
  assign unused_addr_bits = ^{line_addr[ADDR_W-1:QW_LSB+QW_IW], line_addr[QW_LSB-1:0]};

  ecc_syn_remap #(.SYN_W(SYN_W), .RC_W(RC_W)) u_remap (
    .syn(syn_code), .in_range(rm_in), .is_multi(rm_multi), .rcode(rcode)
  );

  ecc_loc_addr #(
    .QW_BITS(QW_BITS), .LINE_QW(LINE_QW), .QW_IW(QW_IW),
    .RC_W(RC_W), .OFF_W(OFF_W), .DB_W(DB_W)
  ) u_addr (
    .wide(wide_mode), .qw(qw), .rcode(rcode),
    .off(off), .dbyte(dbyte), .shift(shift)
  );

  // ---------------- tables
  logic sym_q;
  logic rd_set;
  logic [MAP_W-1:0] drd, prd;

  always_ff @(posedge clk) begin
    if (rst) sym_q <= 1'b1;
    else if (tbl_we && tbl_sel == TSEL_SYM) sym_q <= tbl_wdata[0];
  end

  assign rd_set = wide_mode & ~sym_q;

  ecc_loc_ram #(.AW(DB_W + 1), .DW(MAP_W)) u_dmap (
    .clk(clk),
    .we(tbl_we && tbl_sel == TSEL_DMAP),
    .waddr({tbl_set, tbl_addr[DB_W-1:0]}),
    .wdata(tbl_wdata),
    .re(req),
    .raddr({rd_set, dbyte}),
    .rdata(drd)
  );

  ecc_loc_ram #(.AW(OFF_W + 1), .DW(MAP_W)) u_pmap (
    .clk(clk),
    .we(tbl_we && tbl_sel == TSEL_PMAP),
    .waddr({tbl_set, tbl_addr}),
    .wdata(tbl_wdata),
    .re(req),
    .raddr({rd_set, off}),
    .rdata(prd)
  );

  // ---------------- request stage
  logic            done_q, inv_q, multi_q, wide_q;
  logic [DI_W-1:0] first_q;
  logic [2:0]      shift_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q  <= 1'b0;
      inv_q   <= 1'b0;
      multi_q <= 1'b0;
      wide_q  <= 1'b0;
      first_q <= '0;
      shift_q <= '0;
    end else begin
      done_q <= req;
      if (req) begin
        inv_q   <= ~rm_in;
        multi_q <= rm_multi;
        wide_q  <= wide_mode;
        first_q <= wide_mode ? DI_W'(grp_sel * WIDE_GRP) : DI_W'(grp_sel * NARROW_GRP);
        shift_q <= shift;
      end
    end
  end

  // ---------------- result
  logic [1:0]      field;
  logic [DI_W-1:0] sel_idx;
  logic            single;

  assign field   = 2'((drd >> shift_q) & (wide_q ? MAP_W'(3) : MAP_W'(1)));
  assign sel_idx = first_q + DI_W'(field);
  assign single  = done_q && !inv_q && !multi_q;

  always_comb begin
    done      = done_q;
    invalid   = done_q && inv_q;
    multi     = done_q && multi_q && !inv_q;
    dimm_idx  = '0;
    dimm_mask = '0;
    pin       = '0;
    if (single) begin
      dimm_idx  = sel_idx;
      dimm_mask = NDIMM'(1) << sel_idx;
      pin       = prd;
    end else if (multi) begin
      dimm_idx  = first_q;
      dimm_mask = (wide_q ? NDIMM'((1 << WIDE_GRP) - 1)
                          : NDIMM'((1 << NARROW_GRP) - 1)) << first_q;
    end
  end

  // ---------------- assertions
  p_done_follows_req_r9: assert property (@(posedge clk) disable iff (rst)
    req |=> done);
  p_done_needs_req_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(req));
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !done |-> (dimm_mask == '0 && pin == '0 && !invalid && !multi));
  p_invalid_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    invalid |-> (!multi && dimm_mask == '0 && pin == '0));
  p_multi_width_r2: assert property (@(posedge clk) disable iff (rst)
    multi |-> ($countones(dimm_mask) == ($past(wide_mode) ? WIDE_GRP : NARROW_GRP)));
  p_single_onehot_r5: assert property (@(posedge clk) disable iff (rst)
    (done && !invalid && !multi) |-> ($countones(dimm_mask) == 1));
  p_remap_range_r3: assert property (@(posedge clk) disable iff (rst)
    (rm_in && !rm_multi) |-> (int'(rcode) < QW_BITS));
  p_offset_range_r4: assert property (@(posedge clk) disable iff (rst)
    (req && wide_mode) |-> (int'(off) < LINE_BITS));
endmodule

// File: tb/sim_ecc_dimm_locator.sv
module sim_ecc_dimm_locator;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wide_mode = 1'b0;
  logic tbl_we = 1'b0;
  logic [1:0] tbl_sel = '0;
  logic tbl_set = 1'b0;
  logic [9:0] tbl_addr = '0;
  logic [7:0] tbl_wdata = '0;
  logic req = 1'b0;
  logic signed [9:0] syn_code = '0;
  logic [15:0] line_addr = '0;
  logic grp_sel = 1'b0;
  logic done, invalid, multi;
  logic [2:0] dimm_idx;
  logic [7:0] dimm_mask, pin;

  always #4 clk = ~clk;

  ecc_dimm_locator u0 (.*);

  typedef struct {
    string tag;
    int inv, mul, dimm, mask, pin;
  } exp_t;

  exp_t q[$];
  int total = 0, bad = 0;
  int bdm [2][256];
  int bpm [2][1024];
  bit bsym = 1'b1;

  task automatic chk(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int remap(int c);
    if (c < 128) return c + 16;
    if (c <= 136) return c - 121;
    if (c <= 139) return c - 133;
    return c - 140;
  endfunction

  function automatic exp_t model(string tag, int c, bit wide, int a, bit g);
    exp_t e;
    int s, off, inv, fld, first;
    e.tag = tag; e.inv = 0; e.mul = 0; e.dimm = 0; e.mask = 0; e.pin = 0;
    s = (wide && !bsym) ? 1 : 0;
    first = wide ? g * 4 : g * 2;
    if (c < -1 || c > 144) begin
      e.inv = 1;
    end else if (c == -1) begin
      e.mul = 1; e.dimm = first;
      e.mask = (wide ? 15 : 3) << first;
    end else if (wide) begin
      off = (3 - ((a >> 4) & 3)) * 144 + remap(c);
      inv = 575 - off;
      fld = (bdm[s][inv / 4] >> ((3 - inv % 4) * 2)) & 3;
      e.dimm = first + fld; e.mask = 1 << e.dimm; e.pin = bpm[s][off];
    end else begin
      off = remap(c);
      inv = 143 - off;
      fld = (bdm[0][inv / 8] >> (7 - inv % 8)) & 1;
      e.dimm = first + fld; e.mask = 1 << e.dimm; e.pin = bpm[0][off];
    end
    return e;
  endfunction

  // monitor: compare each done result with the oldest expectation
  always @(negedge clk) begin
    if (!rst && done) begin
      if (q.size() == 0) chk("R9", "unexpected done", 1, 0);
      else begin
        exp_t e;
        e = q.pop_front();
        chk(e.tag, "invalid", int'(invalid), e.inv);
        chk(e.tag, "multi", int'(multi), e.mul);
        chk(e.tag, "dimm_idx", int'(dimm_idx), e.dimm);
        chk(e.tag, "dimm_mask", int'(dimm_mask), e.mask);
        chk(e.tag, "pin", int'(pin), e.pin);
      end
    end
  end

  task automatic twrite(logic [1:0] sel, bit set, int addr, int data);
    @(negedge clk);
    tbl_we = 1'b1; tbl_sel = sel; tbl_set = set;
    tbl_addr = 10'(addr); tbl_wdata = 8'(data);
    if (sel == 2'd0) bdm[set][addr] = data & 255;
    else if (sel == 2'd1) bpm[set][addr] = data & 255;
    else bsym = data[0];
  endtask

  // drives one request for one cycle edge; the request stays up until idle()
  task automatic lookup(string tag, int c, bit wide, int a, bit g);
    @(negedge clk);
    tbl_we = 1'b0;
    req = 1'b1; wide_mode = wide; syn_code = 10'(c);
    line_addr = 16'(a); grp_sel = g;
    q.push_back(model(tag, c, wide, a, g));
  endtask

  task automatic idle();
    @(negedge clk);
    req = 1'b0; tbl_we = 1'b0;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk("WATCHDOG", "timeout", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11: reset state
    chk("R11", "done", int'(done), 0);
    chk("R11", "dimm_mask", int'(dimm_mask), 0);
    chk("R11", "pin", int'(pin), 0);
    chk("R11", "invalid", int'(invalid), 0);

    // R8: load both map sets
    for (int s = 0; s < 2; s++) begin
      for (int i = 0; i < 144; i++) twrite(2'd0, s[0], i, i * 37 + s * 91 + 5);
      for (int i = 0; i < 576; i++) twrite(2'd1, s[0], i, i * 7 + s * 3 + 11);
    end
    idle();

    // R11: flag left at 1 -> set 0 (R7); wide sweep over all valid codes (R3, R4, R5, R2)
    for (int c = -1; c <= 144; c++)
      lookup("R3 R4 R5", c, 1'b1, ((c & 3) << 4) | (c & 15) | ((c & 7) << 8), c[2]);
    idle();

    // R7: clear the symmetric flag -> set 1
    twrite(2'd2, 1'b0, 0, 0);
    for (int c = 0; c <= 144; c += 5)
      lookup("R7", c, 1'b1, (c % 4) << 4, c[1]);
    lookup("R7 R2", -1, 1'b1, 0, 1'b1);
    idle();

    // R6: narrow layout ignores address and set selection
    for (int c = -1; c <= 144; c++)
      lookup("R6", c, 1'b0, c * 613, c[0]);
    idle();

    // R1: out-of-range codes in both layouts
    lookup("R1", -2, 1'b1, 16, 1'b0);
    lookup("R1", 145, 1'b1, 32, 1'b1);
    lookup("R1", 300, 1'b0, 0, 1'b1);
    lookup("R1", -300, 1'b0, 48, 1'b0);
    lookup("R1", -7, 1'b1, 0, 1'b1);
    idle();

    // R9: quiet between results
    @(negedge clk);
    chk("R9", "idle done", int'(done), 0);
    chk("R9", "idle pin", int'(pin), 0);

    // R10: pin write and lookup at the same offset in one cycle
    twrite(2'd2, 1'b0, 0, 1);
    @(negedge clk);
    tbl_we = 1'b0;
    // code 50 -> bit 66, quadword 2 -> offset 144+66 = 210
    @(negedge clk);
    req = 1'b1; wide_mode = 1'b1; syn_code = 10'sd50; line_addr = 16'h0020; grp_sel = 1'b0;
    q.push_back(model("R10", 50, 1'b1, 16'h0020, 1'b0));
    tbl_we = 1'b1; tbl_sel = 2'd1; tbl_set = 1'b0; tbl_addr = 10'd210;
    tbl_wdata = 8'(bpm[0][210] ^ 8'hA5);
    bpm[0][210] = bpm[0][210] ^ 8'hA5;
    lookup("R10", 50, 1'b1, 16'h0020, 1'b0);
    idle();

    repeat (4) @(negedge clk);
    chk("R9", "pending results", q.size(), 0);
    finish_run();
  end
endmodule